// File: doc/BRIEF.md
# Pinned-Entry Translation Lookaside Buffer

This block caches virtual-to-physical page translations in two separate stores. The first is an ordinary 2-way set-associative array that takes routine fills. The second is a small fully associative array of eight pinned slots. Entries in the pinned slots stay valid through a bulk flush. An external page-table walker presents each new translation on a fill port. A control word, written and read over a simple register bus, decides which store receives the fill. The control word holds a preserve flag and a 3-bit slot pointer.

A lookup searches both stores in the same cycle and returns a registered hit flag, a flag that tells whether the match came from a pinned slot, and the physical page number. Two invalidation commands are provided. The flush command empties only the set-associative store. The targeted command removes every entry, in either store, whose virtual page number equals the given one.

Top module: `pinned_tlb`

## Requirements
- R1: After reset, no entry is valid in either store, a lookup misses, and `reg_rdata` reads 0.
- R2: The control word carries the slot pointer in bits 28:26 and the preserve flag in bit 0. All other bits read 0 and are ignored on write. `reg_rdata` shows the new value right after the write's clock edge.
- R3: While the preserve flag is 0, a fill goes into the set-associative store, in set `vpn[3:0]`, and leaves the slot pointer unchanged.
- R4: While the preserve flag is 1, a fill goes into the pinned slot that the pointer names, and the pointer then increments, wrapping from 7 to 0.
- R5: A flush command invalidates every set-associative entry and no pinned entry.
- R6: A targeted invalidation removes the entries with a matching virtual page number in both stores.
- R7: Lookup results appear on the first clock edge after `lk_valid`. `lk_hit` and `lk_in_pin` are 0 in any cycle that follows no lookup, and `lk_ppn` is 0 on a miss.
- R8: When both stores match, the pinned entry wins and `lk_in_pin` is 1.
- R9: When a register write and a fill occur in the same cycle, the fill uses the newly written preserve flag and pointer.
- R10: Inside a full set, a fill replaces the way named by that set's round-robin bit, starting at way 0. The bit flips after every fill into the set, so the oldest of the two entries is evicted.
- R11: When a fill and an invalidation occur in the same cycle, the entry just filled is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Current control word |
| fill_valid | input | 1 | Fill request from the walker |
| fill_vpn | input | VPN_W | Virtual page number of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| inv_all | input | 1 | Flush of the set-associative store |
| inv_one | input | 1 | Targeted invalidation |
| inv_vpn | input | VPN_W | Virtual page number for the targeted invalidation |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| lk_hit | output | 1 | Registered hit |
| lk_in_pin | output | 1 | Registered: the hit came from a pinned slot |
| lk_ppn | output | PPN_W | Registered physical page number, 0 on a miss |

## Verification
A lookup request is sampled at one rising edge, and its result is valid after that same edge. A monitor therefore marks each request as it is sampled, then pops one expected item from the scoreboard at the following falling edge and compares it. The control word is not held in a pipeline, so register checks read `reg_rdata` at the falling edge after the write or fill edge. The expected items come from a model that the driver updates in the same order the design uses: lookup against the old state first, then the register write, then the invalidations, then the fill.

// File: rtl/pinned_tlb_pkg.sv
package pinned_tlb_pkg;
  localparam int CTRL_W   = 32;
  localparam int PRES_BIT = 0;
  localparam int VIC_LSB  = 26;
endpackage

// File: rtl/pinned_tlb_ctrl.sv
module pinned_tlb_ctrl
  import pinned_tlb_pkg::*;
#(
  parameter int VIC_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  input  logic              fill_valid,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              fill_pin,
  output logic [VIC_W-1:0]  fill_slot,
  output logic              preserve_q,
  output logic [VIC_W-1:0]  victim_q
);
  logic             pres_n;
  logic [VIC_W-1:0] vic_n;
  logic             unused_wbits;

  assign unused_wbits = ^{reg_wdata[CTRL_W-1:VIC_LSB+VIC_W], reg_wdata[VIC_LSB-1:PRES_BIT+1]};

  // register write is applied before a same-cycle fill
  always_comb begin
    pres_n    = reg_wr ? reg_wdata[PRES_BIT] : preserve_q;
    vic_n     = reg_wr ? reg_wdata[VIC_LSB +: VIC_W] : victim_q;
    fill_pin  = fill_valid & pres_n;
    fill_slot = vic_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preserve_q <= 1'b0;
      victim_q   <= '0;
    end else begin
      preserve_q <= pres_n;
      victim_q   <= fill_pin ? vic_n + 1'b1 : vic_n;
    end
  end

  always_comb begin
    reg_rdata                   = '0;
    reg_rdata[VIC_LSB +: VIC_W] = victim_q;
    reg_rdata[PRES_BIT]         = preserve_q;
  end
endmodule

// File: rtl/pinned_tlb_pin.sv
module pinned_tlb_pin #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             inv_one,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] ppn
);
  logic [N-1:0]     vld;
  logic [VPN_W-1:0] vpn_q [N];
  logic [PPN_W-1:0] ppn_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        if (inv_one && vld[i] && vpn_q[i] == inv_vpn) vld[i] <= 1'b0;
      if (wr_en) vld[wr_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_slot] <= wr_vpn;
      ppn_q[wr_slot] <= wr_ppn;
    end
  end

  // lowest matching slot wins
  always_comb begin
    hit = 1'b0;
    ppn = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i] && vpn_q[i] == lk_vpn) begin
        hit = 1'b1;
        ppn = ppn_q[i];
      end
    end
  end
endmodule

// File: rtl/pinned_tlb_assoc.sv
module pinned_tlb_assoc #(
  parameter int SETS  = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  localparam int SET_W = $clog2(SETS),
  localparam int WAYS  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             inv_all,
  input  logic             inv_one,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] ppn,
  output logic             any_vld
);
  logic [SET_W-1:0]            wr_set, inv_set, lk_set;
  logic [SETS-1:0]             rr_q;
  logic                        wr_way;
  logic [WAYS-1:0]             way_hit;
  logic [WAYS-1:0]             way_any;
  logic [WAYS-1:0][PPN_W-1:0]  way_ppn;

  assign wr_set  = wr_vpn[SET_W-1:0];
  assign inv_set = inv_vpn[SET_W-1:0];
  assign lk_set  = lk_vpn[SET_W-1:0];
  assign wr_way  = rr_q[wr_set];

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (wr_en) rr_q[wr_set] <= ~rr_q[wr_set];
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [VPN_W-1:0] tag_mem [SETS];
    logic [PPN_W-1:0] ppn_mem [SETS];
    logic [SETS-1:0]  vld;
    logic             sel;

    assign sel = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_mem[wr_set] <= wr_vpn;
        ppn_mem[wr_set] <= wr_ppn;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld <= '0;
      end else begin
        if (inv_all) vld <= '0;
        else if (inv_one && vld[inv_set] && tag_mem[inv_set] == inv_vpn) vld[inv_set] <= 1'b0;
        if (sel) vld[wr_set] <= 1'b1;
      end
    end

    assign way_hit[w] = vld[lk_set] && tag_mem[lk_set] == lk_vpn;
    assign way_ppn[w] = ppn_mem[lk_set];
    assign way_any[w] = |vld;
  end

  assign hit     = |way_hit;
  assign ppn     = way_hit[0] ? way_ppn[0] : way_ppn[1];
  assign any_vld = |way_any;
endmodule

// File: rtl/pinned_tlb.sv
module pinned_tlb
  import pinned_tlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int SETS  = 16,
  parameter int PIN_N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              inv_all,
  input  logic              inv_one,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic              lk_in_pin,
  output logic [PPN_W-1:0]  lk_ppn
);
  localparam int VIC_W = $clog2(PIN_N);

  logic             fill_pin, preserve_q;
  logic [VIC_W-1:0] fill_slot, victim_q;
  logic             p_hit, a_hit, a_any_vld;
  logic [PPN_W-1:0] p_ppn, a_ppn;

  pinned_tlb_ctrl #(.VIC_W(VIC_W)) u_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .fill_valid(fill_valid), .reg_rdata(reg_rdata), .fill_pin(fill_pin),
    .fill_slot(fill_slot), .preserve_q(preserve_q), .victim_q(victim_q)
  );

  pinned_tlb_pin #(.N(PIN_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_pin (
    .clk(clk), .rst(rst), .wr_en(fill_pin), .wr_slot(fill_slot),
    .wr_vpn(fill_vpn), .wr_ppn(fill_ppn), .inv_one(inv_one), .inv_vpn(inv_vpn),
    .lk_vpn(lk_vpn), .hit(p_hit), .ppn(p_ppn)
  );

  pinned_tlb_assoc #(.SETS(SETS), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_assoc (
    .clk(clk), .rst(rst), .wr_en(fill_valid & ~fill_pin),
    .wr_vpn(fill_vpn), .wr_ppn(fill_ppn), .inv_all(inv_all), .inv_one(inv_one),
    .inv_vpn(inv_vpn), .lk_vpn(lk_vpn), .hit(a_hit), .ppn(a_ppn), .any_vld(a_any_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit    <= 1'b0;
      lk_in_pin <= 1'b0;
      lk_ppn    <= '0;
    end else begin
      lk_hit    <= lk_valid & (p_hit | a_hit);
      lk_in_pin <= lk_valid & p_hit;
      if (lk_valid && p_hit)      lk_ppn <= p_ppn;
      else if (lk_valid && a_hit) lk_ppn <= a_ppn;
      else                        lk_ppn <= '0;
    end
  end
endmodule

// File: rtl/pinned_tlb_chk.sv
module pinned_tlb_chk #(
  parameter int VIC_W = 3,
  parameter int PPN_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             fill_valid,
  input logic             inv_all,
  input logic             lk_valid,
  input logic             preserve_q,
  input logic [VIC_W-1:0] victim_q,
  input logic             p_hit,
  input logic [PPN_W-1:0] p_ppn,
  input logic             a_any_vld,
  input logic             lk_hit,
  input logic             lk_in_pin,
  input logic [PPN_W-1:0] lk_ppn,
  input logic [31:0]      reg_rdata
);
  localparam logic [31:0] KEEP = (32'((1 << VIC_W) - 1) << 26) | 32'd1;

  p_rdata_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~KEEP) == 32'd0);

  p_assoc_fill_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !preserve_q && !reg_wr) |=> $stable(victim_q));

  p_pin_fill_step_r4: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && preserve_q && !reg_wr) |=> victim_q == VIC_W'($past(victim_q) + 1'b1));

  p_flush_assoc_r5: assert property (@(posedge clk) disable iff (rst)
    (inv_all && !fill_valid) |=> !a_any_vld);

  p_idle_nohit_r7: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!lk_hit && !lk_in_pin));

  p_pin_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && p_hit) |=> (lk_hit && lk_in_pin && lk_ppn == $past(p_ppn)));
endmodule

bind pinned_tlb pinned_tlb_chk #(.VIC_W(VIC_W), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .fill_valid(fill_valid), .inv_all(inv_all),
  .lk_valid(lk_valid), .preserve_q(preserve_q), .victim_q(victim_q), .p_hit(p_hit),
  .p_ppn(p_ppn), .a_any_vld(a_any_vld), .lk_hit(lk_hit), .lk_in_pin(lk_in_pin),
  .lk_ppn(lk_ppn), .reg_rdata(reg_rdata)
);

// File: tb/pinned_tlb_test.sv
module pinned_tlb_test;
  localparam int VW = 20;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 0, fill_valid = 0, inv_all = 0, inv_one = 0, lk_valid = 0;
  logic [31:0]   reg_wdata = '0;
  logic [VW-1:0] fill_vpn = '0, inv_vpn = '0, lk_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic [31:0]   reg_rdata;
  logic          lk_hit, lk_in_pin;
  logic [PW-1:0] lk_ppn;

  always #10 clk = ~clk;

  pinned_tlb uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .inv_all(inv_all), .inv_one(inv_one), .inv_vpn(inv_vpn),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_in_pin(lk_in_pin), .lk_ppn(lk_ppn)
  );

  int n_chk = 0, n_fail = 0;

  // reference model
  bit            m_pv [8];
  logic [VW-1:0] m_pvpn [8];
  logic [PW-1:0] m_pppn [8];
  bit            m_av [16][2];
  logic [VW-1:0] m_avpn [16][2];
  logic [PW-1:0] m_appn [16][2];
  bit            m_rr [16];
  bit            m_pres = 0;
  logic [2:0]    m_vic = '0;

  typedef struct packed { logic hit; logic pin; logic [PW-1:0] ppn; } exp_t;
  exp_t  q_exp [$];
  string q_req [$];

  task automatic cyc(input bit wr, input logic [31:0] wd, input bit fv,
                     input logic [VW-1:0] fvpn, input logic [PW-1:0] fppn,
                     input bit ia, input bit io, input logic [VW-1:0] ivpn,
                     input bit lv, input logic [VW-1:0] lvpn, input string req);
    exp_t e;
    int   s;
    @(negedge clk);
    reg_wr = wr; reg_wdata = wd; fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn;
    inv_all = ia; inv_one = io; inv_vpn = ivpn; lk_valid = lv; lk_vpn = lvpn;
    if (lv) begin
      e = '0;
      for (int i = 7; i >= 0; i--)
        if (m_pv[i] && m_pvpn[i] == lvpn) begin e.hit = 1; e.pin = 1; e.ppn = m_pppn[i]; end
      if (!e.hit) begin
        s = int'(lvpn[3:0]);
        for (int w = 1; w >= 0; w--)
          if (m_av[s][w] && m_avpn[s][w] == lvpn) begin e.hit = 1; e.ppn = m_appn[s][w]; end
      end
      q_exp.push_back(e);
      q_req.push_back(req);
    end
    if (wr) begin m_pres = wd[0]; m_vic = wd[28:26]; end
    if (ia) for (int a = 0; a < 16; a++) begin m_av[a][0] = 0; m_av[a][1] = 0; end
    if (io) begin
      for (int i = 0; i < 8; i++) if (m_pvpn[i] == ivpn) m_pv[i] = 0;
      s = int'(ivpn[3:0]);
      for (int w = 0; w < 2; w++) if (m_avpn[s][w] == ivpn) m_av[s][w] = 0;
    end
    if (fv) begin
      if (m_pres) begin
        m_pv[m_vic] = 1; m_pvpn[m_vic] = fvpn; m_pppn[m_vic] = fppn; m_vic = m_vic + 3'd1;
      end else begin
        s = int'(fvpn[3:0]);
        m_av[s][m_rr[s]] = 1; m_avpn[s][m_rr[s]] = fvpn; m_appn[s][m_rr[s]] = fppn;
        m_rr[s] = ~m_rr[s];
      end
    end
  endtask

  task automatic wreg(input logic [31:0] wd);
    cyc(1, wd, 0, '0, '0, 0, 0, '0, 0, '0, "");
  endtask
  task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p);
    cyc(0, '0, 1, v, p, 0, 0, '0, 0, '0, "");
  endtask
  task automatic look(input logic [VW-1:0] v, input string req);
    cyc(0, '0, 0, '0, '0, 0, 0, '0, 1, v, req);
  endtask
  task automatic flush();
    cyc(0, '0, 0, '0, '0, 1, 0, '0, 0, '0, "");
  endtask
  task automatic kill(input logic [VW-1:0] v);
    cyc(0, '0, 0, '0, '0, 0, 1, v, 0, '0, "");
  endtask

  // idle cycle, then compare the control word against the model
  task automatic chk_reg(input string req);
    logic [31:0] ex;
    cyc(0, '0, 0, '0, '0, 0, 0, '0, 0, '0, "");
    ex = (32'(m_vic) << 26) | 32'(m_pres);
    n_chk++;
    if (reg_rdata !== ex) begin
      n_fail++;
      $display("FAIL %s reg_rdata actual %h expected %h", req, reg_rdata, ex);
    end
  endtask

  // monitor: result due one edge after the request
  logic pend = 0;
  always @(posedge clk) pend <= lk_valid && !rst;
  always @(negedge clk) begin
    exp_t  e;
    string r;
    if (pend) begin
      n_chk++;
      if (q_exp.size() == 0) begin
        n_fail++;
        $display("FAIL R7 unexpected result actual hit=%0b expected none", lk_hit);
      end else begin
        e = q_exp.pop_front();
        r = q_req.pop_front();
        if (lk_hit !== e.hit || lk_in_pin !== e.pin || lk_ppn !== e.ppn) begin
          n_fail++;
          $display("FAIL %s actual hit=%0b pin=%0b ppn=%h expected hit=%0b pin=%0b ppn=%h",
                   r, lk_hit, lk_in_pin, lk_ppn, e.hit, e.pin, e.ppn);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk_reg("R1");
    look(20'h00005, "R1");
    // R2: junk bits ignored, pointer 5, preserve 0
    wreg(32'hF7FF_FFFE);
    chk_reg("R2");
    wreg((32'd6 << 26) | 32'd1);
    chk_reg("R2");
    // R4: pinned fills at 6 and 7, pointer wraps to 0
    fill(20'hAAAA1, 20'h11111);
    fill(20'hBBBB2, 20'h22222);
    chk_reg("R4");
    // R3: preserve off, pointer kept
    wreg(32'd0);
    fill(20'hCCCC3, 20'h33333);
    chk_reg("R3");
    look(20'hAAAA1, "R4");
    look(20'hBBBB2, "R4");
    look(20'hCCCC3, "R3");
    look(20'h12343, "R7");
    // R10: three fills into set 2
    fill(20'h00012, 20'h40001);
    fill(20'h00022, 20'h40002);
    fill(20'h00032, 20'h40003);
    look(20'h00012, "R10");
    look(20'h00022, "R10");
    look(20'h00032, "R10");
    // R9 + R8: same VPN in both stores
    fill(20'hEEEE5, 20'h55550);
    cyc(1, (32'd2 << 26) | 32'd1, 1, 20'hEEEE5, 20'h55551, 0, 0, '0, 0, '0, "");
    chk_reg("R9");
    look(20'hEEEE5, "R8");
    // R5: flush keeps pinned
    flush();
    look(20'hAAAA1, "R5");
    look(20'hCCCC3, "R5");
    look(20'h00022, "R5");
    look(20'hEEEE5, "R5");
    // R6: targeted in both stores
    kill(20'hAAAA1);
    look(20'hAAAA1, "R6");
    look(20'hBBBB2, "R6");
    wreg(32'd0);
    fill(20'h0F0F7, 20'h77777);
    look(20'h0F0F7, "R6");
    kill(20'h0F0F7);
    look(20'h0F0F7, "R6");
    // R11: fill with flush in the same cycle
    cyc(0, '0, 1, 20'h09998, 20'h88888, 1, 0, '0, 0, '0, "");
    look(20'h09998, "R11");
    cyc(0, '0, 1, 20'h0ABC9, 20'h99999, 0, 1, 20'h0ABC9, 0, '0, "");
    look(20'h0ABC9, "R11");
    repeat (4) chk_reg("R3");
    n_chk++;
    if (q_exp.size() != 0) begin
      n_fail++;
      $display("FAIL R7 pending results actual %0d expected 0", q_exp.size());
    end
    finish_run();
  end
endmodule